// File: doc/BRIEF.md
# Memory Write-Path ECC Error Injector

This block sits on the write-data path of a memory controller and corrupts check bits or parity on purpose, so that the error-handling path downstream can be tested. Software programs an address pattern through a small register interface. The pattern has six fields: dimm within its channel, rank, channel, bank, page and column. Each field can match one value or anything. Software also sets an ECC flip mask, a section select that picks the lower half, the upper half or both halves of the check word, a type bit set, and an arm control.

Each access carries its decoded address, its data, its check bits and one parity bit per section. The access leaves one cycle later. The data is always unchanged. When a write access matches the armed pattern, the check bits and/or the parity of the selected sections are altered, and a one-cycle strobe reports the hit together with its channel and dimm. In one-shot mode the unit disarms itself after the first hit. In repeat mode it keeps corrupting until software disarms it.

Top module: `ecc_inject_unit`

## Requirements
- R1: After reset, all six match fields read back as wildcard (bit 31 set, value 0). The mask, section, type and arm registers read 0, and no strobe or valid output is raised.
- R2: Each register can be read back. The register addresses are 0 dimm, 1 rank, 2 channel, 3 bank, 4 page, 5 column, 6 mask, 7 section, 8 type and 9 arm. reg_rdata shows the register selected by reg_raddr one cycle earlier. A match field reads as {wildcard in bit 31, value in the low bits}, and the arm register reads 1 when armed.
- R3: An injection fires only when every field that is not a wildcard equals the matching field of the access.
- R4: A field whose written word has bit 31 set matches any value, independently of the other fields.
- R5: Only accesses with acc_valid and acc_write high can fire. Read accesses pass through unaltered.
- R6: Writing a nonzero value to register 9 arms the unit and writing zero disarms it. While disarmed, no access is corrupted.
- R7: The type register has bit 0 = repeat, bit 1 = ECC and bit 2 = parity. With the ECC bit set, the mask is XORed into check bits [HALF-1:0] when section bit 0 is set and into [CHK_W-1:HALF] when section bit 1 is set. Section 1 selects low, 2 high, 3 both, and 0 means nothing fires.
- R8: With the parity bit set, acc_par[0] is inverted when section bit 0 is set and acc_par[1] when section bit 1 is set.
- R9: With the repeat bit clear, the first injection disarms the unit (register 9 reads 0 afterwards). With it set, every matching write is corrupted.
- R10: Outputs are registered one cycle after the access. out_data equals acc_data. inj_strobe is high for exactly the corrupted access and carries that access's channel and dimm.
- R11: A register write accepted at one clock edge applies to the access presented in the very next cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| reg_we | input | 1 | Register write strobe |
| reg_waddr | input | 4 | Register write address |
| reg_wdata | input | 32 | Register write data |
| reg_raddr | input | 4 | Register read address |
| reg_rdata | output | 32 | Registered read data |
| acc_valid | input | 1 | Access present |
| acc_write | input | 1 | Access is a write |
| acc_dimm | input | DIMM_W | Dimm within channel |
| acc_rank | input | RANK_W | Rank |
| acc_chan | input | CH_W | Channel |
| acc_bank | input | BANK_W | Bank |
| acc_page | input | PAGE_W | Page |
| acc_col | input | COL_W | Column |
| acc_data | input | DATA_W | Outgoing data |
| acc_chk | input | CHK_W | Outgoing check bits |
| acc_par | input | 2 | Parity bit per section |
| out_valid | output | 1 | Access leaving |
| out_data | output | DATA_W | Data, unchanged |
| out_chk | output | CHK_W | Possibly corrupted check bits |
| out_par | output | 2 | Possibly corrupted parity |
| inj_strobe | output | 1 | This access was corrupted |
| inj_chan | output | CH_W | Channel of the corrupted access |
| inj_dimm | output | DIMM_W | Dimm of the corrupted access |

## Verification
Every access result (out_valid, out_data, out_chk, out_par, inj_strobe, inj_chan, inj_dimm) is due at the first rising edge after the access is driven. Read data is due at the first edge after reg_raddr is set. The bench drives inputs on the falling edge and samples 1 ns after the following rising edge, so each check lands in the one cycle where its result is due. Register writes go in the cycle just before a test access, which exercises the next-cycle rule directly. The one-shot disarm is observed both by a missing strobe on a later access and by reading register 9.

// File: rtl/ecc_inj_pkg.sv
package ecc_inj_pkg;
  localparam int unsigned REG_AW  = 4;
  localparam int unsigned REG_DW  = 32;
  localparam int unsigned NFIELD  = 6;
  localparam int unsigned ANY_BIT = REG_DW - 1;

  localparam logic [REG_AW-1:0] RA_MASK = 4'd6;
  localparam logic [REG_AW-1:0] RA_SECT = 4'd7;
  localparam logic [REG_AW-1:0] RA_TYPE = 4'd8;
  localparam logic [REG_AW-1:0] RA_ARM  = 4'd9;

  typedef struct packed {
    logic par;
    logic ecc;
    logic rep;
  } inj_type_t;

  function automatic int unsigned imax(int unsigned a, int unsigned b);
    return (a > b) ? a : b;
  endfunction
endpackage

// File: rtl/inj_regs.sv
module inj_regs
  import ecc_inj_pkg::*;
#(
  parameter int unsigned MAXW   = 16,
  parameter int unsigned MASK_W = 8,
  parameter logic [NFIELD-1:0][MAXW-1:0] FMASK = '1
) (
  input  logic                         clk,
  input  logic                         rst,
  input  logic                         we,
  input  logic [REG_AW-1:0]            waddr,
  input  logic [REG_DW-1:0]            wdata,
  input  logic [REG_AW-1:0]            raddr,
  output logic [REG_DW-1:0]            rdata,
  input  logic                         disarm,
  output logic [NFIELD-1:0][MAXW-1:0]  fld_val,
  output logic [NFIELD-1:0]            fld_any,
  output logic [MASK_W-1:0]            ecc_mask,
  output logic [1:0]                   sect,
  output inj_type_t                    typ,
  output logic                         armed
);
  logic [REG_DW-1:0] rd_next;

  always_ff @(posedge clk) begin
    if (rst) begin
      fld_val  <= '0;
      fld_any  <= '1;
      ecc_mask <= '0;
      sect     <= '0;
      typ      <= '0;
      armed    <= 1'b0;
    end else begin
      if (disarm) armed <= 1'b0;
      if (we) begin
        for (int i = 0; i < NFIELD; i++) begin
          if (waddr == REG_AW'(i)) begin
            fld_val[i] <= wdata[MAXW-1:0] & FMASK[i];
            fld_any[i] <= wdata[ANY_BIT];
          end
        end
        case (waddr)
          RA_MASK: ecc_mask <= wdata[MASK_W-1:0];
          RA_SECT: sect     <= wdata[1:0];
          RA_TYPE: typ      <= wdata[2:0];
          RA_ARM:  armed    <= |wdata;
          default: ;
        endcase
      end
    end
  end

  always_comb begin
    rd_next = '0;
    for (int i = 0; i < NFIELD; i++) begin
      if (raddr == REG_AW'(i)) begin
        rd_next[ANY_BIT]    = fld_any[i];
        rd_next[MAXW-1:0]   = fld_val[i];
      end
    end
    case (raddr)
      RA_MASK: rd_next[MASK_W-1:0] = ecc_mask;
      RA_SECT: rd_next[1:0]        = sect;
      RA_TYPE: rd_next[2:0]        = typ;
      RA_ARM:  rd_next[0]          = armed;
      default: ;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) rdata <= '0;
    else     rdata <= rd_next;
  end
endmodule

// File: rtl/inj_match.sv
module inj_match
  import ecc_inj_pkg::*;
#(
  parameter int unsigned MAXW = 16
) (
  input  logic [NFIELD-1:0][MAXW-1:0] fld_val,
  input  logic [NFIELD-1:0]           fld_any,
  input  logic [NFIELD-1:0][MAXW-1:0] acc_fld,
  output logic                        hit
);
  logic [NFIELD-1:0] fhit;

  for (genvar g = 0; g < NFIELD; g++) begin : g_field
    assign fhit[g] = fld_any[g] | (fld_val[g] == acc_fld[g]);
  end

  assign hit = &fhit;
endmodule

// File: rtl/inj_corrupt.sv
module inj_corrupt
  import ecc_inj_pkg::*;
#(
  parameter int unsigned CHK_W = 16,
  localparam int unsigned HALF = CHK_W / 2
) (
  input  logic             fire,
  input  logic [1:0]       sect,
  input  inj_type_t        typ,
  input  logic [HALF-1:0]  mask,
  input  logic [CHK_W-1:0] chk_in,
  input  logic [1:0]       par_in,
  output logic [CHK_W-1:0] chk_out,
  output logic [1:0]       par_out
);
  for (genvar s = 0; s < 2; s++) begin : g_sect
    logic hit_s;
    assign hit_s = fire & sect[s];
    assign chk_out[s*HALF +: HALF] = chk_in[s*HALF +: HALF] ^ ((hit_s & typ.ecc) ? mask : '0);
    assign par_out[s] = par_in[s] ^ (hit_s & typ.par);
  end
endmodule

// File: rtl/ecc_inject_unit.sv
module ecc_inject_unit
  import ecc_inj_pkg::*;
#(
  parameter int unsigned DIMM_W = 2,
  parameter int unsigned RANK_W = 2,
  parameter int unsigned CH_W   = 2,
  parameter int unsigned BANK_W = 3,
  parameter int unsigned PAGE_W = 16,
  parameter int unsigned COL_W  = 10,
  parameter int unsigned DATA_W = 64,
  parameter int unsigned CHK_W  = 16
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              reg_we,
  input  logic [3:0]        reg_waddr,
  input  logic [31:0]       reg_wdata,
  input  logic [3:0]        reg_raddr,
  output logic [31:0]       reg_rdata,
  input  logic              acc_valid,
  input  logic              acc_write,
  input  logic [DIMM_W-1:0] acc_dimm,
  input  logic [RANK_W-1:0] acc_rank,
  input  logic [CH_W-1:0]   acc_chan,
  input  logic [BANK_W-1:0] acc_bank,
  input  logic [PAGE_W-1:0] acc_page,
  input  logic [COL_W-1:0]  acc_col,
  input  logic [DATA_W-1:0] acc_data,
  input  logic [CHK_W-1:0]  acc_chk,
  input  logic [1:0]        acc_par,
  output logic              out_valid,
  output logic [DATA_W-1:0] out_data,
  output logic [CHK_W-1:0]  out_chk,
  output logic [1:0]        out_par,
  output logic              inj_strobe,
  output logic [CH_W-1:0]   inj_chan,
  output logic [DIMM_W-1:0] inj_dimm
);
  localparam int unsigned HALF = CHK_W / 2;
  localparam int unsigned MAXW = imax(imax(imax(DIMM_W, RANK_W), imax(CH_W, BANK_W)),
                                      imax(PAGE_W, COL_W));
  localparam logic [NFIELD-1:0][MAXW-1:0] FMASK = {
    MAXW'((64'd1 << COL_W)  - 1), MAXW'((64'd1 << PAGE_W) - 1),
    MAXW'((64'd1 << BANK_W) - 1), MAXW'((64'd1 << CH_W)   - 1),
    MAXW'((64'd1 << RANK_W) - 1), MAXW'((64'd1 << DIMM_W) - 1)};

  logic [NFIELD-1:0][MAXW-1:0] fld_val;
  logic [NFIELD-1:0]           fld_any;
  logic [NFIELD-1:0][MAXW-1:0] acc_fld;
  logic [HALF-1:0]             ecc_mask;
  logic [1:0]                  sect_q;
  inj_type_t                   typ_q;
  logic                        armed_q;
  logic                        hit, fire, disarm;
  logic [CHK_W-1:0]            chk_mod;
  logic [1:0]                  par_mod;

  always_comb begin
    acc_fld    = '0;
    acc_fld[0] = MAXW'(acc_dimm);
    acc_fld[1] = MAXW'(acc_rank);
    acc_fld[2] = MAXW'(acc_chan);
    acc_fld[3] = MAXW'(acc_bank);
    acc_fld[4] = MAXW'(acc_page);
    acc_fld[5] = MAXW'(acc_col);
  end

  inj_regs #(.MAXW(MAXW), .MASK_W(HALF), .FMASK(FMASK)) u_regs (
    .clk(clk), .rst(rst), .we(reg_we), .waddr(reg_waddr), .wdata(reg_wdata),
    .raddr(reg_raddr), .rdata(reg_rdata), .disarm(disarm),
    .fld_val(fld_val), .fld_any(fld_any), .ecc_mask(ecc_mask),
    .sect(sect_q), .typ(typ_q), .armed(armed_q));

  inj_match #(.MAXW(MAXW)) u_match (
    .fld_val(fld_val), .fld_any(fld_any), .acc_fld(acc_fld), .hit(hit));

  assign fire   = acc_valid & acc_write & armed_q & hit
                & (typ_q.ecc | typ_q.par) & (|sect_q);
  assign disarm = fire & ~typ_q.rep;

  inj_corrupt #(.CHK_W(CHK_W)) u_corrupt (
    .fire(fire), .sect(sect_q), .typ(typ_q), .mask(ecc_mask),
    .chk_in(acc_chk), .par_in(acc_par), .chk_out(chk_mod), .par_out(par_mod));

  always_ff @(posedge clk) begin
    if (rst) begin
      out_valid  <= 1'b0;
      out_data   <= '0;
      out_chk    <= '0;
      out_par    <= '0;
      inj_strobe <= 1'b0;
      inj_chan   <= '0;
      inj_dimm   <= '0;
    end else begin
      out_valid  <= acc_valid;
      out_data   <= acc_data;
      out_chk    <= chk_mod;
      out_par    <= par_mod;
      inj_strobe <= fire;
      inj_chan   <= fire ? acc_chan : '0;
      inj_dimm   <= fire ? acc_dimm : '0;
    end
  end
endmodule

// File: rtl/inj_checker.sv
module inj_checker #(
  parameter int unsigned DATA_W = 64,
  parameter int unsigned CHK_W  = 16
) (
  input logic              clk,
  input logic              rst,
  input logic              acc_valid,
  input logic              acc_write,
  input logic [DATA_W-1:0] acc_data,
  input logic [CHK_W-1:0]  acc_chk,
  input logic [1:0]        acc_par,
  input logic              reg_we,
  input logic              out_valid,
  input logic [DATA_W-1:0] out_data,
  input logic [CHK_W-1:0]  out_chk,
  input logic [1:0]        out_par,
  input logic              inj_strobe,
  input logic              armed,
  input logic              rep
);
  AST_STROBE_IS_VALID: assert property (@(posedge clk) disable iff (rst)
    inj_strobe |-> out_valid); // R10
  AST_DATA_UNCHANGED: assert property (@(posedge clk) disable iff (rst)
    out_valid |-> out_data == $past(acc_data)); // R10
  AST_ONLY_WRITES: assert property (@(posedge clk) disable iff (rst)
    inj_strobe |-> $past(acc_valid && acc_write)); // R5
  AST_NEEDS_ARM: assert property (@(posedge clk) disable iff (rst)
    inj_strobe |-> $past(armed)); // R6
  AST_QUIET_CHK: assert property (@(posedge clk) disable iff (rst)
    (out_valid && !inj_strobe) |-> (out_chk == $past(acc_chk)
                                     && out_par == $past(acc_par))); // R7
  AST_ONESHOT_DISARM: assert property (@(posedge clk) disable iff (rst)
    (inj_strobe && !rep && !$past(reg_we)) |-> !armed); // R9
endmodule

bind ecc_inject_unit inj_checker #(.DATA_W(DATA_W), .CHK_W(CHK_W)) u_inj_checker (
  .clk(clk), .rst(rst), .acc_valid(acc_valid), .acc_write(acc_write),
  .acc_data(acc_data), .acc_chk(acc_chk), .acc_par(acc_par), .reg_we(reg_we),
  .out_valid(out_valid), .out_data(out_data), .out_chk(out_chk),
  .out_par(out_par), .inj_strobe(inj_strobe), .armed(armed_q), .rep(typ_q.rep));

// File: tb/tb_ecc_inject_unit.sv
`timescale 1ns/1ps
module tb_ecc_inject_unit;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        reg_we = 1'b0;
  logic [3:0]  reg_waddr = '0;
  logic [31:0] reg_wdata = '0;
  logic [3:0]  reg_raddr = '0;
  logic [31:0] reg_rdata;
  logic        acc_valid = 1'b0, acc_write = 1'b0;
  logic [1:0]  acc_dimm = '0, acc_rank = '0, acc_chan = '0;
  logic [2:0]  acc_bank = '0;
  logic [15:0] acc_page = '0;
  logic [9:0]  acc_col = '0;
  logic [63:0] acc_data = '0;
  logic [15:0] acc_chk = '0;
  logic [1:0]  acc_par = '0;
  logic        out_valid, inj_strobe;
  logic [63:0] out_data;
  logic [15:0] out_chk;
  logic [1:0]  out_par, inj_chan, inj_dimm;

  int checks = 0;
  int errors = 0;

  always #2.5 clk = ~clk;

  ecc_inject_unit dut (
    .clk(clk), .rst(rst), .reg_we(reg_we), .reg_waddr(reg_waddr),
    .reg_wdata(reg_wdata), .reg_raddr(reg_raddr), .reg_rdata(reg_rdata),
    .acc_valid(acc_valid), .acc_write(acc_write), .acc_dimm(acc_dimm),
    .acc_rank(acc_rank), .acc_chan(acc_chan), .acc_bank(acc_bank),
    .acc_page(acc_page), .acc_col(acc_col), .acc_data(acc_data),
    .acc_chk(acc_chk), .acc_par(acc_par), .out_valid(out_valid),
    .out_data(out_data), .out_chk(out_chk), .out_par(out_par),
    .inj_strobe(inj_strobe), .inj_chan(inj_chan), .inj_dimm(inj_dimm));

  typedef struct packed {
    logic        wr;
    logic [1:0]  ch;
    logic [1:0]  dimm;
    logic [15:0] page;
    logic [9:0]  col;
    logic [15:0] chk;
    logic        strobe;
    logic [15:0] echk;
  } vec_t;

  // config: channel = 2, all else wildcard, mask 0x41, section 3, type repeat+ECC
  localparam vec_t VECS [6] = '{
    '{1'b1, 2'd2, 2'd1, 16'h0010, 10'h001, 16'h0000, 1'b1, 16'h4141},
    '{1'b1, 2'd1, 2'd1, 16'h0010, 10'h001, 16'h1234, 1'b0, 16'h1234},
    '{1'b0, 2'd2, 2'd1, 16'h0010, 10'h001, 16'h1234, 1'b0, 16'h1234},
    '{1'b1, 2'd2, 2'd3, 16'hBEEF, 10'h3FF, 16'hFFFF, 1'b1, 16'hBEBE},
    '{1'b1, 2'd0, 2'd3, 16'hBEEF, 10'h3FF, 16'hA5A5, 1'b0, 16'hA5A5},
    '{1'b1, 2'd2, 2'd0, 16'h7777, 10'h155, 16'h4141, 1'b1, 16'h0000}};

  task automatic check(input bit ok, input string req, input logic [63:0] act,
                       input logic [63:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [3:0] a, input logic [31:0] d);
    @(negedge clk);
    reg_we = 1'b1; reg_waddr = a; reg_wdata = d;
    @(posedge clk); #1;
    reg_we = 1'b0;
  endtask

  task automatic rd(input logic [3:0] a, input logic [31:0] exp, input string req);
    @(negedge clk);
    reg_raddr = a;
    @(posedge clk); #1;
    check(reg_rdata == exp, req, 64'(reg_rdata), 64'(exp));
  endtask

  task automatic acc(input logic w, input logic [1:0] ch, input logic [1:0] dm,
                     input logic [2:0] bk, input logic [15:0] pg, input logic [9:0] cl,
                     input logic [15:0] ck, input logic [1:0] pr,
                     input logic es, input logic [15:0] eck, input logic [1:0] epr,
                     input string req);
    logic [63:0] d;
    d = {pg, ck, 6'd0, cl, 16'hC0DE};
    @(negedge clk);
    acc_valid = 1'b1; acc_write = w; acc_chan = ch; acc_dimm = dm; acc_bank = bk;
    acc_page = pg; acc_col = cl; acc_chk = ck; acc_par = pr; acc_data = d;
    @(posedge clk); #1;
    acc_valid = 1'b0;
    check(out_valid == 1'b1, req, 64'(out_valid), 64'd1);
    check(inj_strobe == es, req, 64'(inj_strobe), 64'(es));
    check(out_chk == eck, req, 64'(out_chk), 64'(eck));
    check(out_par == epr, req, 64'(out_par), 64'(epr));
    check(out_data == d, {req, " R10 data"}, out_data, d);
    if (es) begin
      check(inj_chan == ch, {req, " R10 chan"}, 64'(inj_chan), 64'(ch));
      check(inj_dimm == dm, {req, " R10 dimm"}, 64'(inj_dimm), 64'(dm));
    end
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    errors++;
    $display("FAIL watchdog expired");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (3) @(posedge clk);
    #1;
    check(out_valid == 1'b0 && inj_strobe == 1'b0, "R1 outputs in reset",
          64'({out_valid, inj_strobe}), 64'd0);
    @(negedge clk); rst = 1'b0;
    rd(4'd0, 32'h8000_0000, "R1 dimm wildcard");
    rd(4'd5, 32'h8000_0000, "R1 column wildcard");
    rd(4'd9, 32'h0, "R1 disarmed");
    rd(4'd6, 32'h0, "R1 mask zero");

    // configure, still disarmed
    wr(4'd6, 32'h41); wr(4'd7, 32'h3); wr(4'd8, 32'h3);
    acc(1'b1, 2'd2, 2'd1, 3'd0, 16'h0, 10'h0, 16'h0000, 2'b00,
        1'b0, 16'h0000, 2'b00, "R6 disarmed no corruption");
    rd(4'd6, 32'h41, "R2 mask readback");
    rd(4'd7, 32'h3, "R2 section readback");
    rd(4'd8, 32'h3, "R2 type readback");
    wr(4'd0, 32'h0000_0003);
    rd(4'd0, 32'h0000_0003, "R2 dimm value readback");
    wr(4'd0, 32'h8000_0000);

    // table walk: channel 2 only
    wr(4'd2, 32'h0000_0002); wr(4'd9, 32'h5);
    rd(4'd9, 32'h1, "R6 armed by nonzero");
    for (int i = 0; i < 6; i++) begin
      acc(VECS[i].wr, VECS[i].ch, VECS[i].dimm, 3'd0, VECS[i].page, VECS[i].col,
          VECS[i].chk, 2'b00, VECS[i].strobe, VECS[i].echk, 2'b00,
          "R3 R4 R5 R7 table");
    end
    rd(4'd9, 32'h1, "R9 repeat stays armed");

    // R11: bank write applies to next cycle access
    wr(4'd3, 32'h0000_0005);
    acc(1'b1, 2'd2, 2'd0, 3'd4, 16'h0, 10'h0, 16'h0, 2'b00,
        1'b0, 16'h0, 2'b00, "R11 new bank field immediate");
    acc(1'b1, 2'd2, 2'd0, 3'd5, 16'h0, 10'h0, 16'h0, 2'b00,
        1'b1, 16'h4141, 2'b00, "R3 two fields match");
    acc(1'b1, 2'd3, 2'd0, 3'd5, 16'h0, 10'h0, 16'h0, 2'b00,
        1'b0, 16'h0, 2'b00, "R3 one field differs");
    wr(4'd3, 32'h8000_0000);

    // sections
    wr(4'd7, 32'h1);
    acc(1'b1, 2'd2, 2'd0, 3'd1, 16'h0, 10'h0, 16'h0, 2'b00,
        1'b1, 16'h0041, 2'b00, "R7 low section");
    wr(4'd7, 32'h2);
    acc(1'b1, 2'd2, 2'd0, 3'd1, 16'h0, 10'h0, 16'h0, 2'b00,
        1'b1, 16'h4100, 2'b00, "R7 high section");
    wr(4'd7, 32'h0);
    acc(1'b1, 2'd2, 2'd0, 3'd1, 16'h0, 10'h0, 16'h0, 2'b00,
        1'b0, 16'h0, 2'b00, "R7 no section no fire");

    // parity
    wr(4'd8, 32'h5); wr(4'd7, 32'h2);
    acc(1'b1, 2'd2, 2'd1, 3'd0, 16'h0, 10'h0, 16'h1111, 2'b00,
        1'b1, 16'h1111, 2'b10, "R8 parity high");
    wr(4'd7, 32'h3);
    acc(1'b1, 2'd2, 2'd1, 3'd0, 16'h0, 10'h0, 16'h1111, 2'b01,
        1'b1, 16'h1111, 2'b10, "R8 parity both");

    // one-shot
    wr(4'd8, 32'h2);
    acc(1'b1, 2'd2, 2'd2, 3'd0, 16'h0, 10'h0, 16'h0, 2'b00,
        1'b1, 16'h4141, 2'b00, "R9 one-shot first");
    acc(1'b1, 2'd2, 2'd2, 3'd0, 16'h0, 10'h0, 16'h0, 2'b00,
        1'b0, 16'h0, 2'b00, "R9 one-shot second");
    rd(4'd9, 32'h0, "R9 self disarmed");

    // zero write disarms
    wr(4'd8, 32'h3); wr(4'd9, 32'h1); wr(4'd9, 32'h0);
    acc(1'b1, 2'd2, 2'd2, 3'd0, 16'h0, 10'h0, 16'h0, 2'b00,
        1'b0, 16'h0, 2'b00, "R6 zero write disarms");

    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule